// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an EDO DRAM array alive. After reset it keeps every strobe inactive for a long power-up pause. It then runs a fixed number of warm-up refresh cycles while normal accesses are still held off. Only after that does it raise its init-done flag.

From then on, an interval timer adds one unit of refresh debt every refresh period. Whenever debt is owed, the block asks the access sequencer for the bus. Each refresh cycle it completes pays back one unit. Refreshes that a long access delays are therefore caught up later. When the debt reaches a set level, an urgent flag tells the access sequencer to stop starting new accesses.

A parameter selects the refresh style:

- **CAS-before-RAS:** the default. WE is held high for the whole cycle.
- **RAS-only:** CAS stays high, and an internal row counter drives the address.

Top module: `dram_refresh_seq`

## Requirements
- R1: After reset is released, bus_own_o stays low and ras_n_o, cas_n_o stay high for the first PAUSE_CYC clock edges.
- R2: After the pause, exactly WARM_CNT refresh cycles run without any grant. init_done_o rises at edge PAUSE_CYC + WARM_CNT*(SETUP_CYC+RAS_CYC+PRE_CYC+1) and then stays high. req_o is low while init_done_o is low.
- R3: In CAS-before-RAS mode (RAS_ONLY=0), cas_n_o falls SETUP_CYC cycles before ras_n_o falls and stays low until ras_n_o rises.
- R4: we_n_o is high whenever ras_n_o is low.
- R5: Each refresh holds ras_n_o low for exactly RAS_CYC cycles. Between two RAS low pulses, ras_n_o is high for at least PRE_CYC cycles.
- R6: After init, the refresh debt increases by one every INTERVAL_CYC cycles. req_o is high while the debt is nonzero and no refresh is in progress.
- R7: After init, a refresh starts only on a cycle where req_o and gnt_i are both high. Each completed refresh lowers the debt by one. While gnt_i stays high, refreshes run back to back until the debt is zero.
- R8: The debt saturates at 2^DEBT_W-1. Extra interval ticks are lost, not wrapped.
- R9: urgent_o is high exactly when the debt is at least URGENT_LVL.
- R10: In RAS-only mode (RAS_ONLY=1), cas_n_o stays high. addr_o carries a row counter that starts at 0, advances by one after every refresh and wraps from 2^ROW_W-1 to 0.
- R11: While reset is asserted, and whenever the block does not own the bus, ras_n_o, cas_n_o and we_n_o are high. During reset, init_done_o and req_o are also low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gnt_i | input | 1 | Bus grant from the access sequencer |
| req_o | output | 1 | Refresh owed, bus requested |
| urgent_o | output | 1 | Debt at or above urgent level |
| init_done_o | output | 1 | Power-up pause and warm-up complete |
| bus_own_o | output | 1 | Block is driving the strobes |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | ROW_W | Refresh row address (RAS-only mode), else zero |

## Verification
The assertions take for granted that the access sequencer treats gnt_i as a level. They also assume it raises gnt_i only while it has left RAS high, and that it stays off the strobes while bus_own_o is high. The stimulus keeps gnt_i low through the whole pause and warm-up, and changes it only on falling clock edges. The RAS-only instance holds its grant high permanently, so its row counter sees every refresh that the debt calls for.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_RAS,
    PH_PRE
  } ref_phase_e;
endpackage

// File: rtl/ref_powerup.sv
module ref_powerup #(
  parameter int PAUSE_CYC = 40000,
  parameter int WARM_CNT  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cyc_done_i,
  output logic warm_run_o,
  output logic init_done_o
);
  localparam int PW = (PAUSE_CYC > 1) ? $clog2(PAUSE_CYC) : 1;
  localparam int WW = (WARM_CNT > 1) ? $clog2(WARM_CNT) : 1;

  logic [PW-1:0] pause_cnt;
  logic [WW-1:0] warm_cnt;
  logic          pause_over;
  logic          init_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pause_cnt  <= '0;
      warm_cnt   <= '0;
      pause_over <= 1'b0;
      init_done  <= 1'b0;
    end else if (!pause_over) begin
      if (pause_cnt == PW'(PAUSE_CYC - 1)) pause_over <= 1'b1;
      else pause_cnt <= pause_cnt + 1'b1;
    end else if (!init_done && cyc_done_i) begin
      if (warm_cnt == WW'(WARM_CNT - 1)) init_done <= 1'b1;
      else warm_cnt <= warm_cnt + 1'b1;
    end
  end

  assign warm_run_o  = pause_over && !init_done;
  assign init_done_o = init_done;
endmodule

// File: rtl/ref_debt.sv
module ref_debt #(
  parameter int INTERVAL_CYC = 1560,
  parameter int DEBT_W       = 3,
  parameter int URGENT_LVL   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic done_i,
  output logic pending_o,
  output logic urgent_o
);
  localparam int IW = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;
  localparam logic [DEBT_W-1:0] DMAX = '1;

  logic [IW-1:0]     tmr;
  logic [DEBT_W-1:0] debt;
  logic              tick;
  logic              pay;

  assign tick = run_i && (tmr == IW'(INTERVAL_CYC - 1));
  assign pay  = run_i && done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr  <= '0;
      debt <= '0;
    end else begin
      if (run_i) tmr <= tick ? '0 : tmr + 1'b1;
      case ({tick, pay})
        2'b10:   if (debt != DMAX) debt <= debt + 1'b1;
        2'b01:   debt <= debt - 1'b1;
        default: debt <= debt;
      endcase
    end
  end

  assign pending_o = (debt != '0);
  assign urgent_o  = (debt >= DEBT_W'(URGENT_LVL));
endmodule

// File: rtl/ref_cycle_fsm.sv
module ref_cycle_fsm
  import dram_refresh_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int RAS_CYC   = 12,
  parameter int PRE_CYC   = 8,
  parameter int ROW_W     = 13,
  parameter bit RAS_ONLY  = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             idle_o,
  output logic             done_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic             we_n_o,
  output logic [ROW_W-1:0] addr_o
);
  localparam int MAX_A = (SETUP_CYC > RAS_CYC) ? SETUP_CYC : RAS_CYC;
  localparam int MAX_C = (MAX_A > PRE_CYC) ? MAX_A : PRE_CYC;
  localparam int CW    = (MAX_C > 1) ? $clog2(MAX_C) : 1;

  ref_phase_e    phase, phase_d;
  logic [CW-1:0] cnt, cnt_d;
  logic          ras_q, cas_q;

  always_comb begin
    phase_d = phase;
    cnt_d   = cnt + 1'b1;
    case (phase)
      PH_IDLE: begin
        cnt_d = '0;
        if (start_i) phase_d = PH_SETUP;
      end
      PH_SETUP: if (cnt == CW'(SETUP_CYC - 1)) begin phase_d = PH_RAS; cnt_d = '0; end
      PH_RAS:   if (cnt == CW'(RAS_CYC - 1))   begin phase_d = PH_PRE; cnt_d = '0; end
      PH_PRE:   if (cnt == CW'(PRE_CYC - 1))   begin phase_d = PH_IDLE; cnt_d = '0; end
      default: begin phase_d = PH_IDLE; cnt_d = '0; end
    endcase
  end

  // strobes registered from next phase: same timing as phase, glitch-free pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      ras_q <= 1'b1;
      cas_q <= 1'b1;
    end else begin
      phase <= phase_d;
      cnt   <= cnt_d;
      ras_q <= (phase_d != PH_RAS);
      cas_q <= RAS_ONLY ? 1'b1 : !((phase_d == PH_SETUP) || (phase_d == PH_RAS));
    end
  end

  assign idle_o  = (phase == PH_IDLE);
  assign done_o  = (phase == PH_PRE) && (cnt == CW'(PRE_CYC - 1));
  assign ras_n_o = ras_q;
  assign cas_n_o = cas_q;
  assign we_n_o  = 1'b1;

  generate
    if (RAS_ONLY) begin : g_row
      logic [ROW_W-1:0] row_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     row_q <= '0;
        else if (done_o) row_q <= row_q + 1'b1;
      end
      assign addr_o = row_q;
    end else begin : g_norow
      assign addr_o = '0;
    end
  endgenerate
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int PAUSE_CYC    = 40000,
  parameter int WARM_CNT     = 8,
  parameter int INTERVAL_CYC = 1560,
  parameter int SETUP_CYC    = 1,
  parameter int RAS_CYC      = 12,
  parameter int PRE_CYC      = 8,
  parameter int DEBT_W       = 3,
  parameter int URGENT_LVL   = 4,
  parameter int ROW_W        = 13,
  parameter bit RAS_ONLY     = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gnt_i,
  output logic             req_o,
  output logic             urgent_o,
  output logic             init_done_o,
  output logic             bus_own_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic             we_n_o,
  output logic [ROW_W-1:0] addr_o
);
  logic warm_run, init_done, pending, idle, done, start;

  ref_powerup #(.PAUSE_CYC(PAUSE_CYC), .WARM_CNT(WARM_CNT)) u_pwr (
    .clk_i(clk_i), .rst_ni(rst_ni), .cyc_done_i(done),
    .warm_run_o(warm_run), .init_done_o(init_done)
  );

  ref_debt #(.INTERVAL_CYC(INTERVAL_CYC), .DEBT_W(DEBT_W), .URGENT_LVL(URGENT_LVL)) u_debt (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(init_done), .done_i(done),
    .pending_o(pending), .urgent_o(urgent_o)
  );

  // warm-up owns the bus without grant: accesses are held off by init_done_o
  assign start = idle && (warm_run || (init_done && pending && gnt_i));

  ref_cycle_fsm #(.SETUP_CYC(SETUP_CYC), .RAS_CYC(RAS_CYC), .PRE_CYC(PRE_CYC),
                  .ROW_W(ROW_W), .RAS_ONLY(RAS_ONLY)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .idle_o(idle), .done_o(done),
    .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o), .addr_o(addr_o)
  );

  assign req_o       = init_done && pending && idle;
  assign init_done_o = init_done;
  assign bus_own_o   = !idle;
endmodule

// File: rtl/dram_refresh_chk.sv
module dram_refresh_chk #(
  parameter int RAS_CYC  = 12,
  parameter bit RAS_ONLY = 1'b0
) (
  input logic clk_i,
  input logic rst_ni,
  input logic gnt_i,
  input logic req_o,
  input logic init_done_o,
  input logic bus_own_o,
  input logic ras_n_o,
  input logic cas_n_o,
  input logic we_n_o
);
  logic [15:0] lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lo_cnt <= '0;
    else if (!ras_n_o) lo_cnt <= lo_cnt + 1'b1;
    else               lo_cnt <= '0;
  end

  a_r2_no_req_before_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_o |-> !req_o);
  a_r2_init_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);
  a_r3_cas_before_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!RAS_ONLY && $fell(ras_n_o)) |-> (!cas_n_o && $past(!cas_n_o)));
  a_r3_cas_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!RAS_ONLY && !ras_n_o) |-> !cas_n_o);
  a_r4_we_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n_o |-> we_n_o);
  a_r5_ras_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> (lo_cnt == 16'(RAS_CYC)));
  a_r7_start_on_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_done_o && $rose(bus_own_o)) |-> $past(req_o && gnt_i));
  a_r10_cas_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (RAS_ONLY && bus_own_o) |-> cas_n_o);
  a_r11_idle_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_own_o |-> (ras_n_o && cas_n_o));
endmodule

bind dram_refresh_seq dram_refresh_chk #(.RAS_CYC(RAS_CYC), .RAS_ONLY(RAS_ONLY)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .gnt_i(gnt_i), .req_o(req_o),
  .init_done_o(init_done_o), .bus_own_o(bus_own_o),
  .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o)
);

// File: tb/dram_refresh_seq_tb_top.sv
`timescale 1ns/1ps
module dram_refresh_seq_tb_top;
  localparam int P   = 20;
  localparam int SU  = 1;
  localparam int RC  = 4;
  localparam int PC  = 3;
  localparam int IV  = 200;
  localparam int L   = SU + RC + PC;
  localparam int INIT_EDGES = P + 8 * (L + 1);

  typedef struct packed {
    logic [15:0] off;
    logic        req;
    logic        urg;
    logic        own;
  } vec_t;

  // debt ticks at init+200k (gnt low): check req/urgent/ownership (R6 R9 R7)
  localparam vec_t VECS [6] = '{
    '{16'd100,  1'b0, 1'b0, 1'b0},
    '{16'd210,  1'b1, 1'b0, 1'b0},
    '{16'd410,  1'b1, 1'b0, 1'b0},
    '{16'd590,  1'b1, 1'b0, 1'b0},
    '{16'd610,  1'b1, 1'b1, 1'b0},
    '{16'd1000, 1'b1, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic gnt = 1'b0;
  logic req, urg, init_done, own, ras_n, cas_n, we_n;
  logic [12:0] addr;
  logic ro_req, ro_urg, ro_init, ro_own, ro_ras, ro_cas, ro_we;
  logic [2:0] ro_addr;

  int checks = 0;
  int errs   = 0;
  int falls  = 0;
  int lo_w   = 0;
  int hi_w   = 0;
  bit seen_hi = 0;
  logic prev_ras = 1'b1, prev_cas = 1'b1;
  int ro_falls = 0;
  logic ro_prev = 1'b1;

  always #2.5 clk = ~clk;

  dram_refresh_seq #(.PAUSE_CYC(P), .WARM_CNT(8), .INTERVAL_CYC(IV), .SETUP_CYC(SU),
    .RAS_CYC(RC), .PRE_CYC(PC), .DEBT_W(3), .URGENT_LVL(3), .ROW_W(13), .RAS_ONLY(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .gnt_i(gnt), .req_o(req), .urgent_o(urg),
    .init_done_o(init_done), .bus_own_o(own), .ras_n_o(ras_n), .cas_n_o(cas_n),
    .we_n_o(we_n), .addr_o(addr));

  dram_refresh_seq #(.PAUSE_CYC(P), .WARM_CNT(8), .INTERVAL_CYC(IV), .SETUP_CYC(SU),
    .RAS_CYC(RC), .PRE_CYC(PC), .DEBT_W(3), .URGENT_LVL(3), .ROW_W(3), .RAS_ONLY(1'b1)) dut_ro_i (
    .clk_i(clk), .rst_ni(rst_ni), .gnt_i(1'b1), .req_o(ro_req), .urgent_o(ro_urg),
    .init_done_o(ro_init), .bus_own_o(ro_own), .ras_n_o(ro_ras), .cas_n_o(ro_cas),
    .we_n_o(ro_we), .addr_o(ro_addr));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  endtask

  // strobe monitor, CAS-before-RAS instance
  always @(negedge clk) begin
    if (!rst_ni) begin
      prev_ras = 1'b1; prev_cas = 1'b1; lo_w = 0; hi_w = 0; seen_hi = 0;
    end else begin
      if (prev_ras && !ras_n) begin
        falls++;
        check(!prev_cas && !cas_n, "R3 cas low before ras fall", prev_cas, 0);
        check(we_n, "R4 we high at ras fall", we_n, 1);
        if (seen_hi) check(hi_w >= PC, "R5 precharge width", hi_w, PC);
        lo_w = 0;
      end
      if (!ras_n) begin
        lo_w++;
        if (!(cas_n == 1'b0 && we_n == 1'b1)) check(0, "R3 R4 strobes during ras low", {cas_n, we_n}, 1);
      end
      if (!prev_ras && ras_n) begin
        check(lo_w == RC, "R5 ras low width", lo_w, RC);
        hi_w = 0; seen_hi = 1;
      end
      if (ras_n) hi_w++;
      prev_ras = ras_n; prev_cas = cas_n;
    end
  end

  // RAS-only instance: row counter and CAS high
  always @(negedge clk) begin
    if (!rst_ni) begin
      ro_falls = 0; ro_prev = 1'b1;
    end else begin
      if (ro_prev && !ro_ras) begin
        check(ro_cas, "R10 cas high in ras-only", ro_cas, 1);
        check(ro_addr == 3'(ro_falls % 8), "R10 row address", ro_addr, ro_falls % 8);
        if (ro_falls == 8) check(ro_addr == 3'd0, "R10 row wrap to zero", ro_addr, 0);
        ro_falls++;
      end
      ro_prev = ro_ras;
    end
  end

  initial begin
    #(150000 * 5);
    errs++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_sim();
  end

  initial begin
    int n;
    int f0;
    int cur;
    bit r1_ok;
    // R11 reset state
    repeat (3) @(negedge clk);
    check(ras_n && cas_n && we_n, "R11 strobes idle in reset", {ras_n, cas_n, we_n}, 7);
    check(!init_done && !req && !own, "R11 flags low in reset", {init_done, req, own}, 0);
    rst_ni = 1'b1;

    // R1 pause then R2 warm-up
    n = 0; r1_ok = 1;
    do begin
      @(negedge clk); n++;
      if (n <= P && (own || !ras_n || !cas_n)) r1_ok = 0;
    end while (ras_n && n < 1000);
    check(r1_ok, "R1 idle during pause", r1_ok, 1);
    check(n == P + SU + 1, "R1 first ras low sample", n, P + SU + 1);
    check(!init_done, "R2 init low during warm-up", init_done, 0);
    while (!init_done && n < 1000) begin
      @(negedge clk); n++;
      if (!init_done && req) check(0, "R2 req before init", req, 0);
    end
    check(n == INIT_EDGES, "R2 init_done edge", n, INIT_EDGES);
    check(falls == 8, "R2 warm-up count", falls, 8);
    check(ro_falls == 8, "R2 warm-up count ras-only", ro_falls, 8);

    // vector table: gnt held low, debt grows
    cur = 0; f0 = falls;
    foreach (VECS[i]) begin
      repeat (int'(VECS[i].off) - cur) @(negedge clk);
      cur = int'(VECS[i].off);
      check(req == VECS[i].req, "R6 req vs debt", req, VECS[i].req);
      check(urg == VECS[i].urg, "R9 urgent level", urg, VECS[i].urg);
      check(own == VECS[i].own, "R7 no refresh without grant", own, VECS[i].own);
    end
    check(falls == f0, "R7 no ras activity without grant", falls - f0, 0);

    // R8 saturation: 10 ticks owed, 7 held; then R7 payback
    repeat (2010 - cur) @(negedge clk);
    check(init_done, "R2 init sticky", init_done, 1);
    f0 = falls; gnt = 1'b1; n = 0;
    do begin @(negedge clk); n++; end while ((req || own) && n < 300);
    gnt = 1'b0;
    check(falls - f0 == 7, "R8 saturated debt paid", falls - f0, 7);
    check(!req && !urg, "R7 debt cleared", {req, urg}, 0);
    check(ro_falls >= 10, "R10 ras-only refreshes ran", ro_falls, 10);

    // R11 mid-run reset
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    check(!init_done && !own && !req, "R11 reset clears flags", {init_done, own, req}, 0);
    check(ras_n && cas_n && ro_ras && ro_addr == 3'd0, "R11 strobes and row after reset",
          {ras_n, cas_n, ro_ras, ro_addr}, 56);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    check(!own && ras_n, "R1 pause restarts", {own, ras_n}, 1);
    finish_sim();
  end
endmodule